// File: doc/BRIEF.md
# Dual-Order Burst Address Counter

This block produces the address for a four-beat memory burst. A load strobe captures a starting address. The low two bits then step through the burst while the upper bits stay at the value that was loaded. The order of the low bits is chosen by a static mode input:

- **Linear:** the low bits count upward modulo four from the start value.
- **Interleaved:** the low bits are the start value XORed with the beat number.

The burst moves forward only on cycles where the active-low advance input is asserted. On other cycles it holds its place, so a burst can be suspended and then resumed. A new start address can be loaded on any cycle, and that restarts the burst without losing a cycle.

Internally the block keeps the loaded start address and a separate beat counter. A small mapping stage combines the start bits and the beat number into the output low bits. A parameter can fix the block to one order at elaboration. In that case the mode input is ignored and the unused mapping logic is never built.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, the output address is all zeros.
- R2: In the cycle after `load` is high, `addr_out` equals the `load_addr` value that was presented, and the beat number restarts at zero.
- R3: The bits of `addr_out` above the two burst bits change only in the cycle after a load.
- R4: With `order_sel` = 0 (linear), the low two bits after n advances equal (start + n) modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_sel` = 1 (interleaved), the low two bits after n advances equal start XOR n. For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R6: The fifth beat of a burst (four advances after the load) returns the output to the loaded start address, in both orders.
- R7: In a cycle with `load` low and `adv_n` high, the output address keeps its value (burst suspend). A later advance continues the sequence from the beat where it stopped.
- R8: When `load` and `adv_n` = 0 are both present in the same cycle, the load wins. Loads on consecutive cycles each take effect in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture `load_addr` as the new burst start |
| load_addr | input | ADDR_W | Starting address of the burst |
| adv_n | input | 1 | Active-low advance to the next burst beat |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; tie high when unused |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The checker assumes that `order_sel` does not change in the middle of a burst. Its stepping properties compare each cycle's address against the previous one under the order in effect. Its suspend property excuses any cycle in which the mode input moved. It also assumes that every control input is at a known level once reset is released. The stimulus holds to both assumptions: the bench changes `order_sel` only in the same cycle as a load, and it drives every input from reset onward.

// File: rtl/bac_pkg.sv
package bac_pkg;

   // Which burst orders a build supports.
   typedef enum logic [1:0] {
      ORD_BOTH   = 2'd0,
      ORD_LINEAR = 2'd1,
      ORD_XOR    = 2'd2
   } order_support_e;

   // Runtime order encoding on the mode input.
   typedef enum logic {
      SEQ_LINEAR = 1'b0,
      SEQ_XOR    = 1'b1
   } seq_order_e;

endpackage

// File: rtl/bac_start_reg.sv
module bac_start_reg #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   output logic [ADDR_W-1:0] start_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (load) begin
         start_q <= load_addr;
      end
   end

endmodule

// File: rtl/bac_beat_ctr.sv
module bac_beat_ctr #(
   parameter int BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  restart,
   input  logic                  step,
   output logic [BURST_BITS-1:0] beat_q
);

   localparam logic [BURST_BITS-1:0] ONE = BURST_BITS'(1);

   // A restart overrides a step taken in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (restart) begin
         beat_q <= '0;
      end else if (step) begin
         beat_q <= beat_q + ONE;
      end
   end

endmodule

// File: rtl/bac_seq_map.sv
module bac_seq_map
   import bac_pkg::*;
#(
   parameter int             BURST_BITS = 2,
   parameter order_support_e ORDERS     = ORD_BOTH
) (
   input  logic [BURST_BITS-1:0] start_lo,
   input  logic [BURST_BITS-1:0] beat,
   input  logic                  order_sel,
   output logic [BURST_BITS-1:0] addr_lo
);

   generate
      if (ORDERS == ORD_LINEAR) begin : g_lin_only
         logic unused_sel;
         assign unused_sel = order_sel;
         assign addr_lo    = start_lo + beat;
      end else if (ORDERS == ORD_XOR) begin : g_xor_only
         logic unused_sel;
         assign unused_sel = order_sel;
         assign addr_lo    = start_lo ^ beat;
      end else begin : g_both
         logic [BURST_BITS-1:0] lin_lo;
         logic [BURST_BITS-1:0] xor_lo;
         assign lin_lo = start_lo + beat;
         assign xor_lo = start_lo ^ beat;
         always_comb begin
            case (seq_order_e'(order_sel))
               SEQ_LINEAR: addr_lo = lin_lo;
               default:    addr_lo = xor_lo;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bac_pkg::*;
#(
   parameter int             ADDR_W     = 20,
   parameter int             BURST_BITS = 2,
   parameter order_support_e ORDERS     = ORD_BOTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              adv_n,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int HI_W = ADDR_W - BURST_BITS;

   generate
      if (BURST_BITS < 1 || BURST_BITS > 8) begin : g_bad_burst
         $error("burst_addr_gen: BURST_BITS out of range");
      end
      if (HI_W < 1) begin : g_bad_width
         $error("burst_addr_gen: ADDR_W must exceed BURST_BITS");
      end
   endgenerate

   logic [ADDR_W-1:0]     start_q;
   logic [BURST_BITS-1:0] beat_q;
   logic [BURST_BITS-1:0] addr_lo;

   bac_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (load_addr),
      .start_q   (start_q)
   );

   bac_beat_ctr #(.BURST_BITS(BURST_BITS)) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .step    (!adv_n),
      .beat_q  (beat_q)
   );

   bac_seq_map #(.BURST_BITS(BURST_BITS), .ORDERS(ORDERS)) u_map (
      .start_lo  (start_q[BURST_BITS-1:0]),
      .beat      (beat_q),
      .order_sel (order_sel),
      .addr_lo   (addr_lo)
   );

   assign addr_out = {start_q[ADDR_W-1:BURST_BITS], addr_lo};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
   import bac_pkg::*;
#(
   parameter int             ADDR_W     = 20,
   parameter int             BURST_BITS = 2,
   parameter order_support_e ORDERS     = ORD_BOTH
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load,
   input logic [ADDR_W-1:0] load_addr,
   input logic              adv_n,
   input logic              order_sel,
   input logic [ADDR_W-1:0] addr_out
);

   logic                  eff_xor;
   logic [BURST_BITS-1:0] lo;

   assign eff_xor = (ORDERS == ORD_XOR) ? 1'b1 :
                    (ORDERS == ORD_LINEAR) ? 1'b0 : order_sel;
   assign lo      = addr_out[BURST_BITS-1:0];

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (addr_out == '0));

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_out == $past(load_addr)));

   // R3
   upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (addr_out[ADDR_W-1:BURST_BITS] == $past(addr_out[ADDR_W-1:BURST_BITS])));

   // R4
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n && !eff_xor) |=>
         (eff_xor || lo == BURST_BITS'($past(lo) + 1'b1)));

   // R5
   xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n && eff_xor) |=>
         (!eff_xor || $countones(lo ^ $past(lo)) >= 1));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv_n) |=>
         (order_sel != $past(order_sel) || addr_out == $past(addr_out)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
   .ADDR_W     (ADDR_W),
   .BURST_BITS (BURST_BITS),
   .ORDERS     (ORDERS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (load),
   .load_addr (load_addr),
   .adv_n     (adv_n),
   .order_sel (order_sel),
   .addr_out  (addr_out)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

   localparam int AW = 20;

   typedef struct {
      logic [AW-1:0] exp;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic          adv_n = 1'b1;
   logic          order_sel = 1'b1;
   logic [AW-1:0] addr_out;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   item_t sb_q[$];

   logic [AW-1:0] m_start = '0;
   logic [1:0]    m_beat = '0;
   logic          m_xor = 1'b1;

   always #5 clk = ~clk;

   burst_addr_gen u_burst_addr_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (load_addr),
      .adv_n     (adv_n),
      .order_sel (order_sel),
      .addr_out  (addr_out)
   );

   task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: addr_out=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one cycle and queue the address expected after the next edge.
   task automatic step(input logic ld, input logic [AW-1:0] a, input logic adv,
                       input logic mode, input string tag);
      item_t it;
      @(negedge clk);
      load = ld; load_addr = a; adv_n = adv; order_sel = mode;
      m_xor = mode;
      if (ld) begin
         m_start = a; m_beat = 2'd0;
      end else if (!adv) begin
         m_beat = m_beat + 2'd1;
      end
      it.exp = {m_start[AW-1:2], m_xor ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat)};
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: compare each result after the edge that produced it.
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check(addr_out, it.exp, it.tag);
      end
   end

   initial begin
      #100000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #1 check(addr_out, '0, "R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1 check(addr_out, '0, "R1 after release");

      // Linear from 01, four advances wrap back to start (R4, R6)
      step(1, 20'hABC41, 1, 0, "R2 load linear");
      for (int i = 0; i < 3; i++) step(0, 20'h0, 0, 0, "R4 linear step");
      step(0, 20'h0, 0, 0, "R6 linear wrap");
      // Interleaved from 01 and 10 (R5, R6)
      step(1, 20'h13571, 1, 1, "R2 load xor");
      for (int i = 0; i < 3; i++) step(0, 20'h0, 0, 1, "R5 xor step 01");
      step(0, 20'h0, 0, 1, "R6 xor wrap");
      step(1, 20'hFFFF2, 1, 1, "R2 load xor 10");
      for (int i = 0; i < 4; i++) step(0, 20'h0, 0, 1, "R5 xor step 10");
      // Suspend and resume (R7)
      step(1, 20'h24683, 1, 0, "R2 load linear 11");
      step(0, 20'h0, 0, 0, "R4 linear 11");
      for (int i = 0; i < 3; i++) step(0, 20'h0, 1, 0, "R7 hold linear");
      step(0, 20'h0, 0, 0, "R7 resume linear");
      step(1, 20'h55553, 1, 1, "R2 load xor 11");
      step(0, 20'h0, 0, 1, "R5 xor 11");
      step(0, 20'h0, 1, 1, "R7 hold xor");
      step(0, 20'h0, 0, 1, "R7 resume xor");
      // Load with advance, back-to-back loads (R8, R3)
      step(0, 20'h0, 0, 1, "R3 upper kept");
      step(1, 20'h0AAA2, 0, 0, "R8 load beats advance");
      step(1, 20'h0BBB1, 0, 0, "R8 back to back");
      step(1, 20'h0CCC3, 1, 1, "R8 back to back");
      step(0, 20'h0, 0, 1, "R5 after reload");
      // Sweep every start value in both orders
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            step(1, {18'(s * 37 + 5), 2'(s)}, 1, m[0], "R2 sweep load");
            for (int k = 0; k < 5; k++)
               step(0, 20'h0, 0, m[0], m[0] ? "R5 sweep" : "R4 sweep");
         end
      end
      step(0, 20'h0, 1, 1, "R7 idle");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule